// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a reconfigurable two-level logic array that computes sum-of-products functions. It has `N_IN` data inputs, `N_OUT` outputs and `N_TERM` product terms. Each output may draw on any of the terms, so several outputs can share one term.

Each data input reaches the AND plane both true and inverted. A product term is the AND of whichever of those literals its map selects. Each output is the OR of whichever product terms its map selects. A per-output force bit drives that output to a constant 1. An output that selects no terms is a constant 0.

The whole map sits in a single serial configuration chain. The chain is loaded one bit per clock while the program-mode input is high. The bit that falls off the far end of the chain is visible on a readback pin, so the stored map can be checked in the order in which it was written.

In run mode the outputs follow the inputs combinationally.

Top module: `sop_array`

## Requirements
- R1: Input i supplies literal 2i (true) and literal 2i+1 (inverted). A product term is 1 exactly when every literal it selects is 1. A term that selects no literal is 1.
- R2: A product term that selects both the true and the inverted literal of the same input is 0 for every input pattern.
- R3: In run mode each output is the OR of the product terms it selects. An output that selects no term and has its force bit clear is 0.
- R4: One product term may be selected by several outputs at the same time, and each of those outputs reflects it.
- R5: An output whose force bit is set is 1 in run mode, whatever the inputs and term selections.
- R6: The chain holds CFG_LEN = N_TERM·2·N_IN + N_OUT·N_TERM + N_OUT bits. Position k is counted from 0 in the order the bits are shifted in, and the positions are assigned as follows:
  - AND-plane bit for term t, literal l: position t·2·N_IN + l.
  - OR-plane bit for output o, term t: position N_TERM·2·N_IN + o·N_TERM + t.
  - Force bit for output o: position N_TERM·2·N_IN + N_OUT·N_TERM + o.

  On each rising clock edge while `prog_en` is high, one bit is taken from `cfg_din`.
- R7: While `prog_en` is high, `out_vec` is all zeros.
- R8: `cfg_done` has the following behaviour:
  - It goes to 0 on the first edge of a program-mode session.
  - It goes to 1 on the edge after the CFG_LEN-th bit of that session is loaded, whether or not program mode has already ended.
  - It otherwise keeps its value.
- R9: `cfg_dout` shows the bit loaded CFG_LEN shifts earlier, so a full session shifts out the previous map in load order. In run mode the stored map and `cfg_dout` do not change, and `cfg_din` has no effect.
- R10: After reset the stored map is all zeros, `cfg_done` is 0 and `out_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | High: program mode (shift the chain, outputs held at 0) |
| cfg_din | input | 1 | Serial configuration data, first-loaded bit first |
| cfg_dout | output | 1 | Readback: the oldest bit in the chain |
| cfg_done | output | 1 | A full map was loaded in the latest session |
| in_vec | input | N_IN | Data inputs |
| out_vec | output | N_OUT | Sum-of-products outputs |

## Verification
The bench builds the array with four inputs, three outputs and six product terms. With four inputs, all 16 input patterns can be swept after every load. The 69-bit chain is short enough to reload several times within a run, including one aborted partial load.

Six terms leave room for the four-term function X·Z + W·Y' + W·X + W'·X'·Y, which a second output shares. They also leave room for one blank term and one self-contradicting term. Reloading over a known map makes the whole previous map visible on the readback pin, in load order.

// File: rtl/sop_pkg.sv
package sop_pkg;
    // Length of the configuration chain: AND plane, OR plane, force bits.
    function automatic int cfg_bits(int n_in, int n_out, int n_term);
        return n_term * 2 * n_in + n_out * n_term + n_out;
    endfunction
endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
    parameter int LEN = 69
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prog_en,
    input  logic           cfg_din,
    output logic [LEN-1:0] map_o,
    output logic           cfg_dout,
    output logic           cfg_done
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(LEN);

    typedef struct packed {
        logic [LEN-1:0] sr;
        logic [CW-1:0]  cnt;
        logic           prog;
        logic           done;
    } chain_t;

    chain_t st_d, st_q;
    logic [CW-1:0] base;

    always_comb begin
        st_d = st_q;
        base = st_q.prog ? st_q.cnt : '0;
        if (prog_en) begin
            st_d.sr  = {st_q.sr[LEN-2:0], cfg_din};
            st_d.cnt = (base == FULL) ? FULL : base + 1'b1;
        end
        if (prog_en && !st_q.prog) begin
            st_d.done = 1'b0;
        end else if (st_q.cnt == FULL) begin
            st_d.done = 1'b1;
        end
        st_d.prog = prog_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign map_o    = st_q.sr;
    assign cfg_dout = st_q.sr[LEN-1];
    assign cfg_done = st_q.done;
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 6
) (
    input  logic [N_IN-1:0]                 in_vec,
    input  logic [N_TERM-1:0][2*N_IN-1:0]   and_sel,
    output logic [N_TERM-1:0]               terms
);
    localparam int LIT = 2 * N_IN;

    logic [LIT-1:0] lits;

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[2*i]   = in_vec[i];
        assign lits[2*i+1] = ~in_vec[i];
    end

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        // an unselected literal contributes a 1
        assign terms[t] = &(lits | ~and_sel[t]);
    end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int N_OUT  = 3,
    parameter int N_TERM = 6
) (
    input  logic                            hold,
    input  logic [N_TERM-1:0]               terms,
    input  logic [N_OUT-1:0][N_TERM-1:0]    or_sel,
    input  logic [N_OUT-1:0]                force_sel,
    output logic [N_OUT-1:0]                out_vec
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        assign out_vec[o] = !hold && (force_sel[o] || (|(terms & or_sel[o])));
    end
endmodule

// File: rtl/sop_array.sv
module sop_array #(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 3,
    parameter int N_TERM = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              cfg_din,
    output logic              cfg_dout,
    output logic              cfg_done,
    input  logic [N_IN-1:0]   in_vec,
    output logic [N_OUT-1:0]  out_vec
);
    localparam int LIT      = 2 * N_IN;
    localparam int AND_BITS = N_TERM * LIT;
    localparam int OR_BITS  = N_OUT * N_TERM;
    localparam int CFG_LEN  = sop_pkg::cfg_bits(N_IN, N_OUT, N_TERM);

    logic [CFG_LEN-1:0]             cfg_map;
    logic [N_TERM-1:0][LIT-1:0]     and_sel;
    logic [N_OUT-1:0][N_TERM-1:0]   or_sel;
    logic [N_OUT-1:0]               force_sel;
    logic [N_TERM-1:0]              terms;

    sop_cfg_chain #(.LEN(CFG_LEN)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .cfg_din  (cfg_din),
        .map_o    (cfg_map),
        .cfg_dout (cfg_dout),
        .cfg_done (cfg_done)
    );

    // load position k sits at chain bit CFG_LEN-1-k
    for (genvar t = 0; t < N_TERM; t++) begin : g_and_map
        for (genvar l = 0; l < LIT; l++) begin : g_lit
            assign and_sel[t][l] = cfg_map[CFG_LEN-1-(t*LIT+l)];
        end
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_or_map
        for (genvar t = 0; t < N_TERM; t++) begin : g_term
            assign or_sel[o][t] = cfg_map[CFG_LEN-1-(AND_BITS+o*N_TERM+t)];
        end
        assign force_sel[o] = cfg_map[CFG_LEN-1-(AND_BITS+OR_BITS+o)];
    end

    sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .in_vec  (in_vec),
        .and_sel (and_sel),
        .terms   (terms)
    );

    sop_or_plane #(.N_OUT(N_OUT), .N_TERM(N_TERM)) u_or (
        .hold      (prog_en),
        .terms     (terms),
        .or_sel    (or_sel),
        .force_sel (force_sel),
        .out_vec   (out_vec)
    );
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int N_OUT = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prog_en,
    input logic             cfg_dout,
    input logic             cfg_done,
    input logic [N_OUT-1:0] out_vec,
    input logic [N_OUT-1:0] force_sel
);
    p_outs_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> (out_vec == '0));

    p_force_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |-> ((out_vec & force_sel) == force_sel));

    p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_en) |=> !cfg_done);

    p_done_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_done) |-> $past(prog_en));

    p_map_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_en && !$past(prog_en)) |-> $stable(cfg_dout));
endmodule

bind sop_array sop_array_chk #(.N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en   (prog_en),
    .cfg_dout  (cfg_dout),
    .cfg_done  (cfg_done),
    .out_vec   (out_vec),
    .force_sel (force_sel)
);

// File: tb/sop_array_tb_top.sv
module sop_array_tb_top;
    localparam int NI  = 4;
    localparam int NO  = 3;
    localparam int NT  = 6;
    localparam int LEN = NT * 2 * NI + NO * NT + NO;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_en = 1'b0;
    logic cfg_din = 1'b0;
    logic [NI-1:0] in_vec = '0;
    logic cfg_dout;
    logic cfg_done;
    logic [NO-1:0] out_vec;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R10";

    // reference state
    int mb[LEN];
    int cfg[LEN];
    int run_len = 0;
    int in_session = 0;
    int exp_done = 0;

    always #5 clk = ~clk;

    sop_array #(.N_IN(NI), .N_OUT(NO), .N_TERM(NT)) dut_i (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout), .cfg_done(cfg_done), .in_vec(in_vec), .out_vec(out_vec)
    );

    function automatic int exp_out(int o);
        int hit = 0;
        if (prog_en) return 0;
        if (mb[NT*2*NI + NO*NT + o] != 0) return 1;
        for (int t = 0; t < NT; t++) begin
            if (mb[NT*2*NI + o*NT + t] != 0) begin
                int ok = 1;
                for (int i = 0; i < NI; i++) begin
                    if (mb[t*2*NI + 2*i] != 0 && in_vec[i] == 1'b0) ok = 0;
                    if (mb[t*2*NI + 2*i + 1] != 0 && in_vec[i] == 1'b1) ok = 0;
                end
                if (ok != 0) hit = 1;
            end
        end
        return hit;
    endfunction

    task automatic compare();
        logic [NO-1:0] eo;
        for (int o = 0; o < NO; o++) eo[o] = exp_out(o) != 0;
        vectors++;
        if (out_vec !== eo) begin
            miscompares++;
            $display("FAIL %s out_vec in=%b actual=%b expected=%b", cur_req, in_vec, out_vec, eo);
        end
        if (cfg_done !== (exp_done != 0)) begin
            miscompares++;
            $display("FAIL R8 cfg_done actual=%b expected=%0d", cfg_done, exp_done);
        end
        if (cfg_dout !== (mb[0] != 0)) begin
            miscompares++;
            $display("FAIL R9 cfg_dout actual=%b expected=%0d", cfg_dout, mb[0]);
        end
    endtask

    // one clock: check between edges, then advance model on the edge
    task automatic cycle();
        int was_full;
        #2;
        compare();
        @(posedge clk);
        was_full = (run_len == LEN);
        if (prog_en) begin
            if (in_session == 0) begin
                run_len = 0;
                exp_done = 0;
            end else if (was_full != 0) begin
                exp_done = 1;
            end
            for (int k = 0; k < LEN - 1; k++) mb[k] = mb[k+1];
            mb[LEN-1] = cfg_din;
            if (run_len < LEN) run_len++;
            in_session = 1;
        end else begin
            if (was_full != 0) exp_done = 1;
            in_session = 0;
        end
        @(negedge clk);
    endtask

    task automatic clear_cfg();
        for (int k = 0; k < LEN; k++) cfg[k] = 0;
    endtask

    task automatic use_lit(int t, int i, int inv);
        cfg[t*2*NI + 2*i + inv] = 1;
    endtask

    task automatic use_term(int o, int t);
        cfg[NT*2*NI + o*NT + t] = 1;
    endtask

    task automatic force_one(int o);
        cfg[NT*2*NI + NO*NT + o] = 1;
    endtask

    task automatic load(int nbits, string req);
        cur_req = req;
        prog_en = 1'b1;
        for (int k = 0; k < nbits; k++) begin
            cfg_din = cfg[k][0];
            cycle();
        end
        prog_en = 1'b0;
        cfg_din = 1'b0;
    endtask

    task automatic sweep(string req);
        cur_req = req;
        for (int v = 0; v < (1 << NI); v++) begin
            in_vec = NI'(v);
            cycle();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int k = 0; k < LEN; k++) mb[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: cleared map, outputs low, done low
        sweep("R10");

        // W=in[3] X=in[2] Y=in[1] Z=in[0]; R1 R3 R4 R6: shared-term function
        clear_cfg();
        use_lit(0, 2, 0); use_lit(0, 0, 0);               // X & Z
        use_lit(1, 3, 0); use_lit(1, 1, 1);               // W & ~Y
        use_lit(2, 3, 0); use_lit(2, 2, 0);               // W & X
        use_lit(3, 3, 1); use_lit(3, 2, 1); use_lit(3, 1, 0); // ~W & ~X & Y
        for (int t = 0; t < 4; t++) use_term(0, t);
        use_term(1, 0); use_term(1, 2);                   // R4 shares t0, t2
        load(LEN, "R7");
        cycle();
        sweep("R1 R3 R4 R6");

        // R1 blank term, R2 contradicting term, R5 forced output
        clear_cfg();
        use_lit(5, 2, 0); use_lit(5, 2, 1);
        use_term(0, 4);
        use_term(1, 5);
        force_one(2);
        load(LEN, "R7 R9");
        sweep("R1 R2 R5");

        // R9: cfg_din ignored in run mode
        cur_req = "R9";
        for (int k = 0; k < 8; k++) begin
            cfg_din = k[0];
            in_vec = NI'(k * 3);
            cycle();
        end
        cfg_din = 1'b0;

        // R8: aborted partial session clears done and leaves it low
        clear_cfg();
        force_one(0); use_term(1, 4);
        load(10, "R7 R8");
        repeat (4) cycle();
        sweep("R8");

        // R9 readback of mixed map, then R8 full reload recovers done
        load(LEN, "R7 R8 R9");
        sweep("R5 R8");
        load(LEN, "R9");
        repeat (3) cycle();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule